// File: doc/BRIEF.md
# UART Line Status Tracker

This block maintains the eight-bit line status word of one UART channel. The channel's receiver, transmitter and storage arrays live elsewhere; they report events to this block through single-cycle strobes. This block keeps only the bookkeeping needed to form the status byte. For each received character it keeps a three-bit error tag (parity, framing, break). It counts the occupancy of the receive and transmit storage, latches overrun, and computes the transmit-ready interrupt request.

Storage works in one of two modes. In holding mode each direction holds a single character. In FIFO mode each direction holds up to `DEPTH` characters (16 by default), and the error flags in the status word describe only the character at the head of the receive queue. A sticky summary bit is set while any stored character carries an error tag.

All strobes are plain, one cycle wide, with no handshake. Nothing can stall a producer: a receive push that finds no room is dropped and reported as overrun, and a transmit write that finds no room is ignored. A push and a pop in the same cycle on full storage are both accepted. Changing the mode input flushes both sides. All other strobes in the cycle where the mode changes are ignored, except that a status read still clears overrun.

Top module: `uart_lsr_track`

## Requirements
- R1: After reset the status byte is 0x60 (bits 5 and 6 set, all others 0).
- R2: Bit 0 is 1 exactly while receive storage holds at least one character (capacity 1 in holding mode, DEPTH in FIFO mode).
- R3: Bits 2, 3 and 4 show the parity, framing and break tags of the head receive character, in arrival order, and are 0 while receive storage is empty.
- R4: Bit 7 is 1 while any stored receive character carries at least one tag, and it drops when the last tagged character is popped.
- R5: A receive push that finds storage full, with no pop in the same cycle, discards the character and sets bit 1. A status read clears bit 1, and a new overrun in the same cycle as the read takes priority.
- R6: In FIFO mode, once a break-tagged character has been stored, further break-tagged pushes are discarded until a push without the break tag arrives. In holding mode every break character is stored.
- R7: In holding mode bit 5 falls at the clock edge that takes a transmit write and rises at the edge that takes a transfer to the shift register. A second write while the holding register is full is ignored.
- R8: In FIFO mode bit 5 is 1 exactly while the transmit FIFO is empty. The FIFO accepts DEPTH writes, and writes beyond that are ignored.
- R9: Bit 6 is 1 only when bit 5 is 1 and the shift-register busy input is 0.
- R10: The interrupt request is 1 exactly when the interrupt enable is 1 and bit 5 is 1.
- R11: A change of the mode input empties both receive and transmit storage at the next edge.
- R12: A push and a pop in the same cycle on full storage are both accepted, and occupancy stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode_i | input | 1 | 1 selects FIFO mode, 0 selects holding mode |
| thre_ie_i | input | 1 | Transmit-ready interrupt enable |
| rx_push_i | input | 1 | A received character enters storage |
| rx_perr_i | input | 1 | Parity error tag of the pushed character |
| rx_ferr_i | input | 1 | Framing error tag (missing stop bit) |
| rx_brk_i | input | 1 | Break tag (line low for a whole frame) |
| rx_pop_i | input | 1 | CPU reads the receive holding register |
| lsr_rd_i | input | 1 | CPU reads the status byte |
| tx_wr_i | input | 1 | CPU writes a transmit character |
| tx_load_i | input | 1 | Transfer of a character into the shift register |
| tx_busy_i | input | 1 | Shift register holds a character |
| lsr_o | output | 8 | Status byte |
| thre_irq_o | output | 1 | Transmit-ready interrupt request |

## Verification
The bench fills receive storage to the limit, then pushes once more. A design with an off-by-one capacity would either store the extra character or flag overrun one character early. It then pushes and pops at the same time on full storage. A design that checks room before the pop would report a false overrun. Runs of break characters in FIFO mode expose a design that stores every break, because more pops than expected are then needed before data ready falls. Popping a tagged character that sits at the tail after clean ones checks that bit 7 follows the whole queue and not just the head. A flush at the mode change catches occupancy carried across modes.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  // Error tag kept beside every stored receive character
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_tag_t;

  // Bit positions inside the status byte
  localparam int unsigned LSR_DR   = 0;
  localparam int unsigned LSR_OE   = 1;
  localparam int unsigned LSR_PE   = 2;
  localparam int unsigned LSR_FE   = 3;
  localparam int unsigned LSR_BI   = 4;
  localparam int unsigned LSR_THRE = 5;
  localparam int unsigned LSR_TEMT = 6;
  localparam int unsigned LSR_ERR  = 7;

endpackage

// File: rtl/lsr_mode_ctl.sv
module lsr_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode_i,
  output logic fifo_mode_o,
  output logic flush_o
);

  logic mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode_i;
  end

  assign fifo_mode_o = fifo_mode_i;
  assign flush_o     = fifo_mode_i ^ mode_q;

endmodule

// File: rtl/lsr_rx_tags.sv
module lsr_rx_tags
  import lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fifo_mode_i,
  input  logic    flush_i,
  input  logic    push_i,
  input  rx_tag_t tag_i,
  input  logic    pop_i,
  input  logic    lsr_rd_i,
  output logic    ready_o,
  output logic    overrun_o,
  output rx_tag_t head_o,
  output logic    any_err_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rx_tag_t          mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt, err_cnt, cap;
  logic             brk_hold, ovr;
  logic             pop_ok, room, drop_brk, acc, ovr_set;
  logic             head_tagged, push_tagged;
  rx_tag_t          head;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign cap         = fifo_mode_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign pop_ok      = pop_i & (cnt != '0) & ~flush_i;
  assign room        = (cnt < cap) | pop_ok;
  assign drop_brk    = fifo_mode_i & brk_hold & push_i & tag_i.brk;
  assign acc         = push_i & ~drop_brk & room & ~flush_i;
  assign ovr_set     = push_i & ~drop_brk & ~room & ~flush_i;
  assign head        = mem[rd_ptr];
  assign head_tagged = |head;
  assign push_tagged = |tag_i;

  always_ff @(posedge clk) begin
    if (acc) mem[wr_ptr] <= tag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      cnt      <= '0;
      err_cnt  <= '0;
      brk_hold <= 1'b0;
    end else if (flush_i) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      cnt      <= '0;
      err_cnt  <= '0;
      brk_hold <= 1'b0;
    end else begin
      if (acc)    wr_ptr <= bump(wr_ptr);
      if (pop_ok) rd_ptr <= bump(rd_ptr);
      case ({acc, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      case ({acc & push_tagged, pop_ok & head_tagged})
        2'b10:   err_cnt <= err_cnt + 1'b1;
        2'b01:   err_cnt <= err_cnt - 1'b1;
        default: err_cnt <= err_cnt;
      endcase
      if (push_i) brk_hold <= fifo_mode_i & tag_i.brk & (acc | drop_brk);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovr <= 1'b0;
    else if (ovr_set)  ovr <= 1'b1;
    else if (lsr_rd_i) ovr <= 1'b0;
  end

  assign ready_o   = (cnt != '0);
  assign overrun_o = ovr;
  assign head_o    = ready_o ? head : '0;
  assign any_err_o = (err_cnt != '0);

endmodule

// File: rtl/lsr_tx_track.sv
module lsr_tx_track #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode_i,
  input  logic flush_i,
  input  logic wr_i,
  input  logic load_i,
  output logic empty_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt, cap;
  logic             ld_ok, wr_ok;

  assign cap   = fifo_mode_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign ld_ok = load_i & (cnt != '0) & ~flush_i;
  assign wr_ok = wr_i & ((cnt < cap) | ld_ok) & ~flush_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (flush_i) cnt <= '0;
    else begin
      case ({wr_ok, ld_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign empty_o = (cnt == '0);

endmodule

// File: rtl/uart_lsr_track.sv
module uart_lsr_track
  import lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode_i,
  input  logic       thre_ie_i,
  input  logic       rx_push_i,
  input  logic       rx_perr_i,
  input  logic       rx_ferr_i,
  input  logic       rx_brk_i,
  input  logic       rx_pop_i,
  input  logic       lsr_rd_i,
  input  logic       tx_wr_i,
  input  logic       tx_load_i,
  input  logic       tx_busy_i,
  output logic [7:0] lsr_o,
  output logic       thre_irq_o
);

  logic    mode, flush;
  logic    rx_ready, rx_ovr, rx_any_err, tx_empty;
  rx_tag_t rx_tag, rx_head;

  assign rx_tag = '{brk: rx_brk_i, ferr: rx_ferr_i, perr: rx_perr_i};

  lsr_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode_i (fifo_mode_i),
    .fifo_mode_o (mode),
    .flush_o     (flush)
  );

  lsr_rx_tags #(.DEPTH(DEPTH)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode_i (mode),
    .flush_i     (flush),
    .push_i      (rx_push_i),
    .tag_i       (rx_tag),
    .pop_i       (rx_pop_i),
    .lsr_rd_i    (lsr_rd_i),
    .ready_o     (rx_ready),
    .overrun_o   (rx_ovr),
    .head_o      (rx_head),
    .any_err_o   (rx_any_err)
  );

  lsr_tx_track #(.DEPTH(DEPTH)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode_i (mode),
    .flush_i     (flush),
    .wr_i        (tx_wr_i),
    .load_i      (tx_load_i),
    .empty_o     (tx_empty)
  );

  always_comb begin
    lsr_o           = '0;
    lsr_o[LSR_DR]   = rx_ready;
    lsr_o[LSR_OE]   = rx_ovr;
    lsr_o[LSR_PE]   = rx_head.perr;
    lsr_o[LSR_FE]   = rx_head.ferr;
    lsr_o[LSR_BI]   = rx_head.brk;
    lsr_o[LSR_THRE] = tx_empty;
    lsr_o[LSR_TEMT] = tx_empty & ~tx_busy_i;
    lsr_o[LSR_ERR]  = rx_any_err;
  end

  assign thre_irq_o = thre_ie_i & tx_empty;

endmodule

// File: rtl/uart_lsr_track_chk.sv
module uart_lsr_track_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_mode_i,
  input logic       thre_ie_i,
  input logic       rx_push_i,
  input logic       rx_brk_i,
  input logic       tx_wr_i,
  input logic       tx_load_i,
  input logic       tx_busy_i,
  input logic [7:0] lsr_o,
  input logic       thre_irq_o
);

  assert_push_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_i && !rx_brk_i && $stable(fifo_mode_i) && $past(rst_n)) |=> lsr_o[0]);

  assert_empty_no_tags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr_o[0] |-> (lsr_o[4:2] == 3'b000));

  assert_empty_no_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr_o[0] |-> !lsr_o[7]);

  assert_overrun_needs_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsr_o[1]) |-> $past(rx_push_i));

  assert_hold_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_i && !tx_load_i && !fifo_mode_i && $stable(fifo_mode_i) && $past(rst_n))
    |=> !lsr_o[5]);

  assert_idle_stays_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_o[5] && !tx_wr_i) |=> lsr_o[5]);

  assert_temt_implies_thre_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_o[6] |-> (lsr_o[5] && !tx_busy_i));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq_o |-> (thre_ie_i && lsr_o[5]));

endmodule

bind uart_lsr_track uart_lsr_track_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_mode_i (fifo_mode_i),
  .thre_ie_i   (thre_ie_i),
  .rx_push_i   (rx_push_i),
  .rx_brk_i    (rx_brk_i),
  .tx_wr_i     (tx_wr_i),
  .tx_load_i   (tx_load_i),
  .tx_busy_i   (tx_busy_i),
  .lsr_o       (lsr_o),
  .thre_irq_o  (thre_irq_o)
);

// File: tb/sim_uart_lsr_track.sv
`timescale 1ns/1ps
module sim_uart_lsr_track;

  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode_i = 1'b0, thre_ie_i = 1'b0;
  logic rx_push_i = 1'b0, rx_perr_i = 1'b0, rx_ferr_i = 1'b0, rx_brk_i = 1'b0;
  logic rx_pop_i = 1'b0, lsr_rd_i = 1'b0;
  logic tx_wr_i = 1'b0, tx_load_i = 1'b0, tx_busy_i = 1'b0;
  logic [7:0] lsr_o;
  logic thre_irq_o;

  always #5 clk = ~clk;

  uart_lsr_track #(.DEPTH(DEPTH)) u0 (.*);

  typedef struct {
    logic [7:0] lsr;
    logic       irq;
    string      req;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0, n_fail = 0;
  bit   done = 0;

  // reference model state
  bit [2:0] mq[$];
  int  txc = 0;
  bit  m_ovr = 0, m_bh = 0, m_mode = 0;

  function automatic exp_t model_out(bit busy, bit ie, string req);
    exp_t e;
    bit any = 0;
    foreach (mq[i]) if (mq[i] != 3'b000) any = 1;
    e.lsr    = '0;
    e.lsr[0] = (mq.size() > 0);
    e.lsr[1] = m_ovr;
    if (mq.size() > 0) e.lsr[4:2] = mq[0];
    e.lsr[5] = (txc == 0);
    e.lsr[6] = (txc == 0) && !busy;
    e.lsr[7] = any;
    e.irq    = ie && (txc == 0);
    e.req    = req;
    return e;
  endfunction

  // driver: tg = {break, framing, parity}
  task automatic step(bit push, bit [2:0] tg, bit pop, bit tw, bit tl,
                      bit busy, bit rd, bit ie, string req);
    int  cap;
    bit  pop_ok, drop, acc, ld_ok, wacc;
    @(negedge clk);
    rx_push_i = push; {rx_brk_i, rx_ferr_i, rx_perr_i} = tg;
    rx_pop_i = pop; tx_wr_i = tw; tx_load_i = tl;
    tx_busy_i = busy; lsr_rd_i = rd; thre_ie_i = ie;
    @(posedge clk);
    #1;
    if (fifo_mode_i != m_mode) begin
      m_mode = fifo_mode_i;
      mq.delete(); txc = 0; m_bh = 0;
      if (rd) m_ovr = 0;
    end else begin
      cap    = m_mode ? DEPTH : 1;
      pop_ok = pop && (mq.size() > 0);
      drop   = m_mode && m_bh && push && tg[2];
      acc    = push && !drop && ((mq.size() < cap) || pop_ok);
      if (pop_ok) void'(mq.pop_front());
      if (acc) mq.push_back(tg);
      if (push) m_bh = m_mode && tg[2] && (acc || drop);
      if (push && !drop && !acc) m_ovr = 1;
      else if (rd) m_ovr = 0;
      ld_ok = tl && (txc > 0);
      wacc  = tw && ((txc < cap) || ld_ok);
      txc   = txc + int'(wacc) - int'(ld_ok);
    end
    sb.push_back(model_out(busy, ie, req));
  endtask

  task automatic idle(string req);
    step(0, 3'b000, 0, 0, 0, 0, 0, thre_ie_i, req);
  endtask

  task automatic set_mode(bit m, string req);
    @(negedge clk);
    fifo_mode_i = m;
    idle(req);
  endtask

  // monitor: compares away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (lsr_o !== e.lsr || thre_irq_o !== e.irq) begin
          n_fail++;
          $display("FAIL %s: lsr=%02h irq=%0b expected lsr=%02h irq=%0b",
                   e.req, lsr_o, thre_irq_o, e.lsr, e.irq);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1");

    // holding mode receive side
    step(1, 3'b001, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 3'b000, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 3'b000, 0, 0, 0, 0, 1, 0, "R5");
    step(0, 3'b000, 1, 0, 0, 0, 0, 0, "R2");
    step(1, 3'b010, 1, 0, 0, 0, 0, 0, "R3");
    step(1, 3'b100, 1, 0, 0, 0, 0, 0, "R12");
    step(1, 3'b100, 1, 0, 0, 0, 0, 0, "R6");
    step(0, 3'b000, 1, 0, 0, 0, 0, 0, "R3");

    // holding mode transmit side
    step(0, 3'b000, 0, 1, 0, 0, 0, 0, "R7");
    step(0, 3'b000, 0, 1, 0, 0, 0, 1, "R7");
    step(0, 3'b000, 0, 0, 1, 1, 0, 1, "R9");
    step(0, 3'b000, 0, 0, 0, 1, 0, 1, "R10");
    step(0, 3'b000, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 3'b000, 0, 1, 1, 0, 0, 1, "R12");

    // leave data behind, then switch mode
    step(1, 3'b001, 0, 0, 0, 0, 0, 0, "R11");
    set_mode(1, "R11");

    // FIFO ordering of tags
    step(1, 3'b000, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 3'b010, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 3'b001, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 3'b100, 0, 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 4; i++) step(0, 3'b000, 1, 0, 0, 0, 0, 0, "R3");

    // break collapse in FIFO mode
    for (int i = 0; i < 3; i++) step(1, 3'b100, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 3'b000, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 3'b100, 0, 0, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(0, 3'b000, 1, 0, 0, 0, 0, 0, "R6");

    // fill to capacity, overrun, simultaneous push and pop
    for (int i = 0; i < DEPTH; i++) step(1, 3'b000, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 3'b001, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 3'b011, 1, 0, 0, 0, 1, 0, "R12");
    step(1, 3'b000, 0, 0, 0, 0, 1, 0, "R5");
    step(0, 3'b000, 0, 0, 0, 0, 1, 0, "R5");
    for (int i = 0; i < DEPTH; i++) step(0, 3'b000, 1, 0, 0, 0, 0, 0, "R4");

    // transmit FIFO depth
    for (int i = 0; i < DEPTH; i++) step(0, 3'b000, 0, 1, 0, 0, 0, 1, "R8");
    step(0, 3'b000, 0, 1, 0, 0, 0, 1, "R8");
    for (int i = 0; i < DEPTH; i++) step(0, 3'b000, 0, 0, 1, 1, 0, 1, "R10");
    step(0, 3'b000, 0, 0, 1, 0, 0, 1, "R8");

    // back to holding mode with transmit data pending
    step(0, 3'b000, 0, 1, 0, 0, 0, 0, "R11");
    set_mode(0, "R11");
    idle("R1");

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule